// File: doc/BRIEF.md
# Protected Power Mode Controller

This block is the power-control register of a small microcontroller, together with the clock-enable outputs that it drives. It holds a serial baud-doubling bit, two general-purpose flags, two arming bits and two start bits. Software enters a low-power state with two separate writes. The first write sets the arming bit. A later write sets the matching start bit, and that write is the last thing the CPU does before its clock stops. A start-bit write whose arming bit is not already set leaves the mode unchanged. This stops a single stray write from halting the core.

In idle the CPU clock and the watchdog clock are gated. The interrupt system, the serial port, the A/D converter and the timers keep their clocks. An interrupt request returns the block to run mode. Power-down gates every clock, and only reset ends it. If both states are requested by the same write, power-down wins. The general-purpose flags survive idle, so after wake-up software can tell where the interrupt arrived.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset `rd_data_o` is 8'h00, `cpu_clk_en_o`, `periph_clk_en_o` and `wdt_clk_en_o` are 1, and `idle_o`, `pdown_o` and `baud_dbl_o` are 0.
- R2: In run mode a write stores bits 7 (baud double), 3 and 2 (flags), 1 (power-down arm) and 0 (idle arm). These bits read back on the clock edge that captures the write. Bit 4 always reads 0.
- R3: When bit 0 is already 1 and a run-mode write sets bit 5, the block enters idle on that edge. From then on `cpu_clk_en_o`=0, `wdt_clk_en_o`=0, `periph_clk_en_o`=1, `idle_o`=1, and bit 5 reads 1.
- R4: When bit 1 is already 1 and a run-mode write sets bit 6, the block enters power-down on that edge. From then on all three clock enables are 0, `pdown_o`=1, and bit 6 reads 1.
- R5: A write of bit 5 or bit 6 while the matching arming bit is not already 1 leaves the mode unchanged, and that start bit reads 0. This holds even when the same write sets the arming bit.
- R6: A write that would start both idle and power-down enters power-down only. Bit 5 stays 0 and `idle_o` stays 0.
- R7: In idle, `irq_i` sampled high returns the block to run mode on that edge. Bits 5 and 0 clear, and bits 7, 3 and 2 keep their values.
- R8: `irq_i` has no effect in run mode or in power-down.
- R9: Writes are ignored while the block is in idle or in power-down.
- R10: An asynchronous reset from idle or from power-down returns the block to the R1 state.
- R11: `baud_dbl_o` equals stored bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| irq_i | input | 1 | Accepted interrupt request |
| rd_data_o | output | 8 | Register read value |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Interrupt/serial/ADC/timer clock enable |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| baud_dbl_o | output | 1 | Baud-rate doubling for serial modes 1-3 |
| idle_o | output | 1 | Block is in idle |
| pdown_o | output | 1 | Block is in power-down |

## Verification
A wrong mode state shows up on the clock enables and on the start bits of `rd_data_o` one edge after the write or interrupt that caused it. One example is a start that does not wait for its arming bit, which shows as a dropped `cpu_clk_en_o`. Another is an idle that ignores its wake-up. Register corruption during a low-power state stays hidden until wake-up, or until it is read in the low-power state itself, so the bench reads the register at both points. Precedence faults appear as `idle_o` and `pdown_o` high together, or as a nonzero bit 5 after a combined start.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int REG_W    = 8;
  localparam int B_BAUD   = 7;
  localparam int B_PD_GO  = 6;
  localparam int B_ID_GO  = 5;
  localparam int B_RSVD   = 4;
  localparam int B_FLAG1  = 3;
  localparam int B_FLAG0  = 2;
  localparam int B_PD_ARM = 1;
  localparam int B_ID_ARM = 0;
  localparam logic [REG_W-1:0] PLAIN_MASK =
    (REG_W'(1) << B_BAUD) | (REG_W'(1) << B_FLAG1) | (REG_W'(1) << B_FLAG0) |
    (REG_W'(1) << B_PD_ARM) | (REG_W'(1) << B_ID_ARM);

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } mode_e;
endpackage

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  logic  idle_go_req_i,
  input  logic  pd_go_req_i,
  input  logic  idle_arm_i,
  input  logic  pd_arm_i,
  input  logic  irq_i,
  output mode_e mode_o,
  output logic  wr_ok_o,
  output logic  enter_idle_o,
  output logic  enter_pd_o,
  output logic  exit_idle_o
);
  mode_e mode_q, mode_d;

  // only a running CPU can write
  assign wr_ok_o      = wr_en_i && (mode_q == MODE_RUN);
  assign enter_pd_o   = wr_ok_o && pd_go_req_i && pd_arm_i;
  assign enter_idle_o = wr_ok_o && idle_go_req_i && idle_arm_i && !enter_pd_o;
  assign exit_idle_o  = (mode_q == MODE_IDLE) && irq_i;

  always_comb begin
    mode_d = mode_q;
    if (enter_pd_o)        mode_d = MODE_PDOWN;
    else if (enter_idle_o) mode_d = MODE_IDLE;
    else if (exit_idle_o)  mode_d = MODE_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RUN;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pmc_reg.sv
module pmc_reg
  import pmc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ok_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             enter_idle_i,
  input  logic             enter_pd_i,
  input  logic             exit_idle_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] q, d;

  always_comb begin
    d = q;
    if (wr_ok_i) d = (q & ~PLAIN_MASK) | (wr_data_i & PLAIN_MASK);
    if (enter_pd_i)   d[B_PD_GO] = 1'b1;
    if (enter_idle_i) d[B_ID_GO] = 1'b1;
    if (exit_idle_i) begin
      d[B_ID_GO]  = 1'b0;
      d[B_ID_ARM] = 1'b0;
    end
    d[B_RSVD] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
  import pmc_pkg::*;
(
  input  mode_e mode_i,
  output logic  cpu_en_o,
  output logic  periph_en_o,
  output logic  wdt_en_o,
  output logic  idle_o,
  output logic  pdown_o
);
  always_comb begin
    idle_o      = (mode_i == MODE_IDLE);
    pdown_o     = (mode_i == MODE_PDOWN);
    cpu_en_o    = (mode_i == MODE_RUN);
    wdt_en_o    = (mode_i == MODE_RUN);
    periph_en_o = (mode_i != MODE_PDOWN);
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             irq_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             cpu_clk_en_o,
  output logic             periph_clk_en_o,
  output logic             wdt_clk_en_o,
  output logic             baud_dbl_o,
  output logic             idle_o,
  output logic             pdown_o
);
  mode_e            mode;
  logic             wr_ok, enter_idle, enter_pd, exit_idle;
  logic [REG_W-1:0] reg_q;

  pmc_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .idle_go_req_i (wr_data_i[B_ID_GO]),
    .pd_go_req_i   (wr_data_i[B_PD_GO]),
    .idle_arm_i    (reg_q[B_ID_ARM]),
    .pd_arm_i      (reg_q[B_PD_ARM]),
    .irq_i         (irq_i),
    .mode_o        (mode),
    .wr_ok_o       (wr_ok),
    .enter_idle_o  (enter_idle),
    .enter_pd_o    (enter_pd),
    .exit_idle_o   (exit_idle)
  );

  pmc_reg u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_ok_i      (wr_ok),
    .wr_data_i    (wr_data_i),
    .enter_idle_i (enter_idle),
    .enter_pd_i   (enter_pd),
    .exit_idle_i  (exit_idle),
    .q_o          (reg_q)
  );

  pmc_clk_gate u_gate (
    .mode_i      (mode),
    .cpu_en_o    (cpu_clk_en_o),
    .periph_en_o (periph_clk_en_o),
    .wdt_en_o    (wdt_clk_en_o),
    .idle_o      (idle_o),
    .pdown_o     (pdown_o)
  );

  assign rd_data_o  = reg_q;
  assign baud_dbl_o = reg_q[B_BAUD];
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       irq_i,
  input logic [7:0] rd_data_o,
  input logic       cpu_clk_en_o,
  input logic       periph_clk_en_o,
  input logic       wdt_clk_en_o,
  input logic       baud_dbl_o,
  input logic       idle_o,
  input logic       pdown_o
);
  logic run;
  assign run = !idle_o && !pdown_o;

  // R3
  idle_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && wr_en_i && wr_data_i[5] && rd_data_o[0] && !(wr_data_i[6] && rd_data_o[1]))
    |=> (idle_o && !cpu_clk_en_o && !wdt_clk_en_o && periph_clk_en_o));

  // R4
  pd_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && wr_en_i && wr_data_i[6] && rd_data_o[1])
    |=> (pdown_o && !cpu_clk_en_o && !wdt_clk_en_o && !periph_clk_en_o));

  // R5
  no_unarmed_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && wr_en_i && !rd_data_o[0] && !(wr_data_i[6] && rd_data_o[1])) |=> run);

  // R6
  pd_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({idle_o, pdown_o}));

  // R7
  irq_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && irq_i) |=> (run && cpu_clk_en_o && !rd_data_o[5]));

  // R8
  pd_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_o |=> pdown_o);

  // R9
  pd_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_o |=> $stable(rd_data_o));

  // R9
  idle_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !irq_i) |=> $stable(rd_data_o));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[4]);
endmodule

bind pwr_mode_ctrl pmc_chk u_chk (.*);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq = 1'b0;
  logic [7:0] rd;
  logic       cpu_en, per_en, wdt_en, baud, idle, pdown;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data), .irq_i(irq),
    .rd_data_o(rd), .cpu_clk_en_o(cpu_en), .periph_clk_en_o(per_en),
    .wdt_clk_en_o(wdt_en), .baud_dbl_o(baud), .idle_o(idle), .pdown_o(pdown)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {cpu, periph, wdt, idle, pdown}
  function automatic logic [4:0] st();
    return {cpu_en, per_en, wdt_en, idle, pdown};
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic pulse_irq();
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd", rd, 8'h00);
    chk("R1 state", st(), 5'b11100);
    chk("R1 baud", baud, 1'b0);
  endtask

  task automatic t_write();
    wr(8'hFF);
    chk("R2 stored", rd, 8'h8F);
    chk("R5 same-write arm", st(), 5'b11100);
    chk("R11 baud set", baud, 1'b1);
    wr(8'h04);
    chk("R2 rewrite", rd, 8'h04);
    chk("R11 baud clear", baud, 1'b0);
    wr(8'h00);
  endtask

  task automatic t_unarmed();
    wr(8'h20);
    chk("R5 idle unarmed", {rd, st()}, {8'h00, 5'b11100});
    wr(8'h40);
    chk("R5 pd unarmed", {rd, st()}, {8'h00, 5'b11100});
  endtask

  task automatic t_irq_run();
    wr(8'h0C);
    pulse_irq();
    chk("R8 irq in run", {rd, st()}, {8'h0C, 5'b11100});
    wr(8'h00);
  endtask

  task automatic t_idle();
    wr(8'h8D);
    wr(8'hAD);
    chk("R3 idle gates", st(), 5'b01010);
    chk("R3 idle rd", rd, 8'hAD);
    wr(8'h00);
    chk("R9 idle write ignored", rd, 8'hAD);
    repeat (4) @(negedge clk);
    chk("R3 idle holds", st(), 5'b01010);
    pulse_irq();
    chk("R7 wake state", st(), 5'b11100);
    chk("R7 wake rd", rd, 8'h8C);
    wr(8'h00);
  endtask

  task automatic t_pdown();
    wr(8'h02);
    wr(8'h42);
    chk("R4 pd gates", st(), 5'b00001);
    chk("R4 pd rd", rd, 8'h42);
    pulse_irq();
    chk("R8 irq in pd", st(), 5'b00001);
    wr(8'h01);
    chk("R9 pd write ignored", rd, 8'h42);
    do_reset();
    chk("R10 reset from pd", {rd, st()}, {8'h00, 5'b11100});
  endtask

  task automatic t_both();
    wr(8'h03);
    wr(8'h63);
    chk("R6 pd wins state", st(), 5'b00001);
    chk("R6 pd wins rd", rd, 8'h43);
    do_reset();
  endtask

  task automatic t_idle_reset();
    wr(8'h01);
    wr(8'h21);
    chk("R3 idle again", st(), 5'b01010);
    do_reset();
    chk("R10 reset from idle", {rd, st()}, {8'h00, 5'b11100});
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_write();
    t_unarmed();
    t_irq_run();
    t_idle();
    t_pdown();
    t_both();
    t_idle_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule